// File: doc/BRIEF.md
# Serial Flash Hold/Reset Pin Qualifier

This block sits on the device side of a serial flash slave. It reads the shared, active-low hold/reset/IO3 pin and decides what that pin means at this moment. Two configuration bits set its role: the quad-enable bit and a role-select bit. With quad enable set, the pin carries data and has no control function. With quad enable clear, the role-select bit picks one of two functions. In hold mode the pin pauses the serial interface. In reset mode the pin issues a reset to the command logic.

The chip select, serial clock and pin inputs pass through a parameterised synchroniser into the system clock domain. The block then drives four things: a hold flag, a clock enable for the shift register, an override that forces the serial output to high impedance, and a one-cycle reset pulse. It also emits a one-cycle abort strobe when chip select is released during a hold. The self-timed program/erase engine appears only as its busy flag. The block passes that flag through as the engine's step enable, so a hold never gates the engine.

Top module: `flash_hold_qual`

## Requirements
- R1: While rst_n is low, hold_active=0, shift_en=0, so_hiz=1, rst_pulse=0 and xfer_abort=0.
- R2: A hold begins only when all of these are true together: chip select is low, SCK is low, the pin is low, quad_en=0 and pin_is_reset=0. A pin falling while SCK is high does not start a hold.
- R3: While hold_active=1, shift_en=0 and so_hiz=1.
- R4: A hold ends only while SCK is low. If the pin returns high while SCK is high, the hold stays active until SCK is next sampled low.
- R5: With quad_en=1 the pin is a data line: no level on it produces a hold or a reset pulse.
- R6: With quad_en=0, pin_is_reset=1 selects the reset function (a low pin never holds), and pin_is_reset=0 selects the hold function.
- R7: While chip select is high, so_hiz=1 and shift_en=0, and any hold is cleared. If a hold was active, xfer_abort pulses for exactly one cycle.
- R8: In reset mode, a low pin sampled for RST_MIN (default 4) consecutive clocks produces exactly one single-cycle rst_pulse per low period. A shorter low produces none.
- R9: eng_step_en equals busy whatever the hold state.
- R10: A change on cs_n, sck or pin_in reaches the outputs SYNC_STAGES+1 clocks later. The pin's inactive (undriven) level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock level |
| pin_in | input | 1 | Shared hold/reset/IO3 pin, active low, 1 when undriven |
| quad_en | input | 1 | 1: pin is a data line |
| pin_is_reset | input | 1 | With quad_en=0: 1 selects reset role, 0 selects hold role |
| busy | input | 1 | Program/erase engine busy |
| hold_active | output | 1 | Hold condition in force |
| shift_en | output | 1 | Clock enable for the serial shift logic |
| so_hiz | output | 1 | Force serial output to high impedance |
| rst_pulse | output | 1 | One-cycle reset to the command logic |
| xfer_abort | output | 1 | One-cycle strobe: transfer aborted by chip select release during hold |
| eng_step_en | output | 1 | Engine advance enable, unaffected by hold |

## Verification
The hold function is driven through one ordered sequence. It separates four cases: a pin falling with SCK low, which enters a hold; a pin falling with SCK high, which is refused; a pin rising with SCK high, which defers the exit; and a pin rising with SCK low, which exits. The same sequence then changes the two configuration bits and shows that one pin level means hold, reset or nothing depending on role. Reset filtering is tried with lows shorter than, equal to and much longer than the threshold, and the bench counts the pulses from each. This separates "ignored", "exactly one" and "repeated". Chip select release during a hold and a busy engine under hold are tried on their own.

// File: rtl/flash_hq_pkg.sv
package flash_hq_pkg;
   typedef enum logic [1:0] {
      ROLE_DATA  = 2'd0,
      ROLE_HOLD  = 2'd1,
      ROLE_RESET = 2'd2
   } pin_role_e;

   function automatic pin_role_e decode_role(input logic qe, input logic rst_sel);
      if (qe)           return ROLE_DATA;
      else if (rst_sel) return ROLE_RESET;
      else              return ROLE_HOLD;
   endfunction
endpackage

// File: rtl/fhq_sync.sv
module fhq_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("fhq_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/fhq_hold_fsm.sv
module fhq_hold_fsm (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic sck_s,
   input  logic pin_s,
   input  logic hold_role,
   output logic hold_q,
   output logic abort_q
);
   logic enter, leave;

   always_comb begin
      enter = !hold_q && hold_role && !pin_s && !sck_s;
      leave =  hold_q && (pin_s || !hold_role) && !sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         abort_q <= hold_q && cs_s;
         if (cs_s)       hold_q <= 1'b0;
         else if (enter) hold_q <= 1'b1;
         else if (leave) hold_q <= 1'b0;
      end
   end
endmodule

// File: rtl/fhq_rst_filter.sv
module fhq_rst_filter #(
   parameter int RST_MIN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_s,
   input  logic reset_role,
   output logic pulse_q
);
   localparam int CW = $clog2(RST_MIN + 1);
   localparam logic [CW-1:0] FIRE = CW'(RST_MIN - 1);
   localparam logic [CW-1:0] SAT  = CW'(RST_MIN);

   if (RST_MIN < 2) begin : g_bad_min
      $error("fhq_rst_filter: RST_MIN must be at least 2");
   end

   logic          low;
   logic [CW-1:0] run_cnt;

   assign low = reset_role && !pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= low && (run_cnt == FIRE);
         if (!low)                run_cnt <= '0;
         else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/flash_hold_qual.sv
module flash_hold_qual
   import flash_hq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RST_MIN     = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic pin_in,
   input  logic quad_en,
   input  logic pin_is_reset,
   input  logic busy,
   output logic hold_active,
   output logic shift_en,
   output logic so_hiz,
   output logic rst_pulse,
   output logic xfer_abort,
   output logic eng_step_en
);
   localparam logic [2:0] IDLE_LEVELS = 3'b101;

   logic [2:0] sync_q;
   logic       cs_s, sck_s, pin_s;
   pin_role_e  role;
   logic       hold_q, abort_q, pulse_q;

   fhq_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_LEVELS)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n, sck, pin_in}),
      .q     (sync_q)
   );

   assign {cs_s, sck_s, pin_s} = sync_q;
   assign role = decode_role(quad_en, pin_is_reset);

   fhq_hold_fsm u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sck_s     (sck_s),
      .pin_s     (pin_s),
      .hold_role (role == ROLE_HOLD),
      .hold_q    (hold_q),
      .abort_q   (abort_q)
   );

   fhq_rst_filter #(.RST_MIN(RST_MIN)) u_rstf (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_s      (pin_s),
      .reset_role (role == ROLE_RESET),
      .pulse_q    (pulse_q)
   );

   assign hold_active = hold_q;
   assign shift_en    = !cs_s && !hold_q;
   assign so_hiz      = cs_s || hold_q;
   assign rst_pulse   = pulse_q;
   assign xfer_abort  = abort_q;
   assign eng_step_en = busy;
endmodule

// File: rtl/flash_hold_qual_chk.sv
module flash_hold_qual_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic sck_s,
   input logic pin_s,
   input logic quad_en,
   input logic pin_is_reset,
   input logic hold_active,
   input logic shift_en,
   input logic so_hiz,
   input logic rst_pulse,
   input logic xfer_abort
);
   // R2 / R6: a hold starts only from a qualified low pin in hold role
   assert_hold_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_active) |-> $past(!cs_s && !sck_s && !pin_s && !quad_en && !pin_is_reset));

   // R3: hold gates the interface
   assert_hold_gates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> (!shift_en && so_hiz));

   // R4 / R7: a hold ends only with SCK low or chip select released
   assert_hold_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_active) |-> $past(!sck_s || cs_s));

   // R7: abort follows a hold cut by chip select
   assert_abort_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_abort |-> ($past(hold_active) && !hold_active));

   // R8: reset pulse is single-cycle and comes from a low pin in reset role
   assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);
   assert_pulse_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> $past(!pin_s && pin_is_reset && !quad_en));
endmodule

bind flash_hold_qual flash_hold_qual_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_s         (cs_s),
   .sck_s        (sck_s),
   .pin_s        (pin_s),
   .quad_en      (quad_en),
   .pin_is_reset (pin_is_reset),
   .hold_active  (hold_active),
   .shift_en     (shift_en),
   .so_hiz       (so_hiz),
   .rst_pulse    (rst_pulse),
   .xfer_abort   (xfer_abort)
);

// File: tb/flash_hold_qual_test.sv
module flash_hold_qual_test;
   localparam int SETTLE = 4; // SYNC_STAGES + 1 register + margin (R10)

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, pin_in = 1'b1, quad_en = 1'b0, pin_is_reset = 1'b0, busy = 1'b0;
   logic hold_active, shift_en, so_hiz, rst_pulse, xfer_abort, eng_step_en;

   int n_run = 0, n_fail = 0;
   int pulses = 0, aborts = 0;
   bit done = 0;

   always #5 clk = ~clk;

   flash_hold_qual uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .pin_in(pin_in),
      .quad_en(quad_en), .pin_is_reset(pin_is_reset), .busy(busy),
      .hold_active(hold_active), .shift_en(shift_en), .so_hiz(so_hiz),
      .rst_pulse(rst_pulse), .xfer_abort(xfer_abort), .eng_step_en(eng_step_en)
   );

   always @(negedge clk) begin
      if (rst_n && rst_pulse)  pulses++;
      if (rst_n && xfer_abort) aborts++;
   end

   // {cs_n, sck, pin, quad_en, pin_is_reset, exp_hold, exp_shift, exp_hiz}
   localparam logic [7:0] VEC [12] = '{
      8'b1_0_1_0_0_0_0_1, // R7 deselected
      8'b0_0_1_0_0_0_1_0, // selected, idle
      8'b0_0_0_0_0_1_0_1, // R2 entry with SCK low; R3
      8'b0_1_1_0_0_1_0_1, // R4 pin high but SCK high: exit deferred
      8'b0_0_1_0_0_0_1_0, // R4 exit once SCK low
      8'b0_1_0_0_0_0_1_0, // R2 pin low with SCK high: no hold
      8'b0_0_0_0_0_1_0_1, // R2 entry when SCK drops
      8'b1_0_0_0_0_0_0_1, // R7 chip select release clears hold
      8'b0_0_0_0_0_1_0_1, // R2 reselected with pin low: hold again
      8'b0_0_1_0_0_0_1_0, // R4 exit
      8'b0_0_0_1_0_0_1_0, // R5 quad: pin low is data
      8'b0_0_0_0_1_0_1_0  // R6 reset role: pin low is no hold
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic low_for(input int n);
      pin_in = 1'b0;
      repeat (n) @(negedge clk);
      pin_in = 1'b1;
      settle();
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check({hold_active, shift_en, so_hiz, rst_pulse, xfer_abort} == 5'b00100,
            "R1", "reset outputs", {hold_active, shift_en, so_hiz, rst_pulse, xfer_abort}, 5'b00100);
      rst_n = 1'b1;
      settle();

      // table walk: R2 R3 R4 R5 R6 R7
      for (int i = 0; i < 12; i++) begin
         {cs_n, sck, pin_in, quad_en, pin_is_reset} = VEC[i][7:3];
         settle();
         check({hold_active, shift_en, so_hiz} == VEC[i][2:0], "R2/R3/R4/R5/R6/R7",
               $sformatf("vector %0d", i), {hold_active, shift_en, so_hiz}, VEC[i][2:0]);
      end
      pin_in = 1'b1; pin_is_reset = 1'b0; quad_en = 1'b0;
      settle();

      // R10 latency: hold shows exactly SYNC_STAGES+1 = 3 clocks after pin falls
      @(negedge clk); pin_in = 1'b0;
      repeat (2) @(negedge clk);
      check(hold_active == 1'b0, "R10", "hold before latency", hold_active, 0);
      @(negedge clk);
      check(hold_active == 1'b1, "R10", "hold at latency", hold_active, 1);

      // R9 busy passes through under hold
      busy = 1'b1; @(negedge clk);
      check(eng_step_en == 1'b1, "R9", "engine enable under hold", eng_step_en, 1);
      busy = 1'b0; @(negedge clk);
      check(eng_step_en == 1'b0, "R9", "engine idle under hold", eng_step_en, 0);

      // R7 abort strobe, exactly one
      aborts = 0;
      cs_n = 1'b1; settle(); settle();
      check(aborts == 1, "R7", "abort pulses", aborts, 1);
      check(hold_active == 1'b0, "R7", "hold cleared", hold_active, 0);
      cs_n = 1'b0; pin_in = 1'b1; settle();

      // R8 reset filter
      pin_is_reset = 1'b1; settle();
      pulses = 0; low_for(2);
      check(pulses == 0, "R8", "short glitch pulses", pulses, 0);
      pulses = 0; low_for(3);
      check(pulses == 0, "R8", "RST_MIN-1 low pulses", pulses, 0);
      pulses = 0; low_for(4);
      check(pulses == 1, "R8", "RST_MIN low pulses", pulses, 1);
      pulses = 0; low_for(40);
      check(pulses == 1, "R8", "long low pulses", pulses, 1);
      check(hold_active == 1'b0, "R6", "reset role no hold", hold_active, 0);

      // R5 quad mode: no reset pulse
      quad_en = 1'b1; settle();
      pulses = 0; low_for(20);
      check(pulses == 0, "R5", "quad pulses", pulses, 0);
      quad_en = 1'b0; pin_is_reset = 1'b0; settle();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule